// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block produces the next micro-address for a microcoded controller. It holds a micro-program counter whose value addresses the control store. Every cycle, the sequencer part of the current microinstruction says how the counter moves. It can return to the fetch routine at address zero, step to the next line, or jump to the routine for the macro-instruction whose opcode is on the input. It can also take a conditional micro-branch.

A micro-branch tests one selected status flag, such as arithmetic overflow or a pending interrupt. When that flag is set, the counter jumps by a signed offset carried in the microinstruction. When it is clear, the counter steps to the next line. Microcode can use this to divert into an exception routine in the middle of an instruction.

The opcode lookup is a combinational table built inside the block. Opcodes that have no routine land on a reserved address that holds the illegal-instruction handler. The datapath-control part of the microinstruction and the control store contents lie outside the block.

Top module: `useq_top`

## Requirements
- R1: A synchronous active-high `rst` loads micro-address 0x00 at the next rising clock edge, whatever mode is applied in that cycle.
- R2: Mode code 0 (`seqMode`=0, fetch) sets `uAddr` to 0x00 at the next edge.
- R3: Mode code 1 (`seqMode`=1, dispatch) with an opcode from 0 to 5 sets `uAddr` to 0x10 + 8*opcode at the next edge (0x10, 0x18, 0x20, 0x28, 0x30, 0x38).
- R4: Dispatch with any opcode of 6 or above sets `uAddr` to the reserved illegal-instruction address 0xF0.
- R5: Mode code 2 (`seqMode`=2, sequential) sets `uAddr` to its current value plus one, modulo 256, so 0xFF steps to 0x00.
- R6: Mode code 3 (`seqMode`=3, micro-branch) tests flag `condFlags[condSel]`. The flag bits are: bit 0 overflow, bit 1 pending interrupt, bit 2 zero, bit 3 negative. When the tested flag is 1, `uAddr` becomes the current value plus the two's-complement 5-bit `brOffset`, modulo 256.
- R7: In micro-branch mode with the tested flag at 0, `uAddr` becomes the current value plus one, modulo 256.
- R8: In micro-branch mode, flag bits other than the selected one have no effect on the next `uAddr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the micro-PC updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset to the fetch entry |
| opcode | input | 6 | Macro-instruction opcode used by dispatch |
| condFlags | input | 4 | Status flags: overflow, pending interrupt, zero, negative (bits 0 to 3) |
| seqMode | input | 2 | Next-address mode: 0 fetch, 1 dispatch, 2 sequential, 3 micro-branch |
| condSel | input | 2 | Index of the flag tested by a micro-branch |
| brOffset | input | 5 | Signed micro-branch offset |
| uAddr | output | 8 | Current micro-address (micro-PC) |

## Verification
Two things can be requested in the same cycle. Reset can arrive in the same cycle as a dispatch command. A micro-branch can also see several flags raised together, where only the selected one should count. The bench applies reset while dispatch mode is driven with a legal opcode, and it expects address 0x00 rather than the routine address. It also applies branches in which every unselected flag is set while the selected one is clear, and the reverse. Each of these is judged by the micro-address one edge later: the value plus the offset, or the value plus one.

// File: rtl/useq_pkg.sv
package useq_pkg;

  // Next-address mode codes carried in the sequencer part of a microinstruction
  typedef enum logic [1:0] {
    MODE_FETCH  = 2'd0,
    MODE_DISP   = 2'd1,
    MODE_SEQ    = 2'd2,
    MODE_BRANCH = 2'd3
  } seqMode_e;

  // One-hot source selects passed from control to the datapath
  typedef struct packed {
    logic goFetch;
    logic goDisp;
    logic goSeq;
    logic goBranch;
  } seqStrobe_t;

endpackage

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int OP_W        = 6,
  parameter int UA_W        = 8,
  parameter int N_COND      = 4,
  parameter int CSEL_W      = $clog2(N_COND),
  parameter int N_DISP      = 6,
  parameter int DISP_BASE   = 'h10,
  parameter int DISP_STRIDE = 8,
  parameter int ILLEGAL_UA  = 'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  input  logic [N_COND-1:0] condFlags,
  input  logic [1:0]        seqMode,
  input  logic [CSEL_W-1:0] condSel,
  output seqStrobe_t        strobe,
  output logic [UA_W-1:0]   dispTarget
);

  localparam int N_OPS = 2 ** OP_W;

  // Opcode-to-routine table, one entry per opcode value
  logic [UA_W-1:0] dispRom [N_OPS];

  for (genvar i = 0; i < N_OPS; i++) begin : g_disp
    if (i < N_DISP) begin : g_legal
      assign dispRom[i] = UA_W'(DISP_BASE + i * DISP_STRIDE);
    end else begin : g_illegal
      assign dispRom[i] = UA_W'(ILLEGAL_UA);
    end
  end

  assign dispTarget = dispRom[opcode];

  logic condTrue;
  assign condTrue = condFlags[condSel];

  always_comb begin
    strobe = '0;
    unique case (seqMode_e'(seqMode))
      MODE_FETCH:  strobe.goFetch  = 1'b1;
      MODE_DISP:   strobe.goDisp   = 1'b1;
      MODE_SEQ:    strobe.goSeq    = 1'b1;
      MODE_BRANCH: begin
        strobe.goBranch = condTrue;
        strobe.goSeq    = !condTrue;
      end
      default:     strobe.goFetch  = 1'b1;
    endcase
  end

  // R6 R7: exactly one next-address source is chosen every cycle
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(strobe) == 1);

endmodule

// File: rtl/useq_path.sv
module useq_path
  import useq_pkg::*;
#(
  parameter int UA_W  = 8,
  parameter int OFF_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  seqStrobe_t       strobe,
  input  logic [UA_W-1:0]  dispTarget,
  input  logic [OFF_W-1:0] brOffset,
  output logic [UA_W-1:0]  uPc
);

  localparam int EXT_W = UA_W - OFF_W;

  logic [UA_W-1:0] incAddr;
  logic [UA_W-1:0] offExt;
  logic [UA_W-1:0] brAddr;
  logic [UA_W-1:0] nextPc;

  assign incAddr = uPc + UA_W'(1);
  assign offExt  = {{EXT_W{brOffset[OFF_W-1]}}, brOffset};
  assign brAddr  = uPc + offExt;

  always_comb begin
    nextPc = '0;
    if (strobe.goDisp)   nextPc = dispTarget;
    if (strobe.goSeq)    nextPc = incAddr;
    if (strobe.goBranch) nextPc = brAddr;
  end

  always_ff @(posedge clk) begin
    if (rst) uPc <= '0;
    else     uPc <= nextPc;
  end

  // R5 R7: an increment strobe advances the micro-PC by exactly one
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.goSeq |=> uPc == UA_W'($past(uPc) + 1));

  // R2: a fetch strobe returns the micro-PC to the fetch entry
  fetch_zero_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.goFetch |=> uPc == '0);

endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int OP_W        = 6,
  parameter int UA_W        = 8,
  parameter int N_COND      = 4,
  parameter int CSEL_W      = $clog2(N_COND),
  parameter int OFF_W       = 5,
  parameter int N_DISP      = 6,
  parameter int DISP_BASE   = 'h10,
  parameter int DISP_STRIDE = 8,
  parameter int ILLEGAL_UA  = 'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  input  logic [N_COND-1:0] condFlags,
  input  logic [1:0]        seqMode,
  input  logic [CSEL_W-1:0] condSel,
  input  logic [OFF_W-1:0]  brOffset,
  output logic [UA_W-1:0]   uAddr
);

  seqStrobe_t      strobe;
  logic [UA_W-1:0] dispTarget;

  useq_ctrl #(
    .OP_W(OP_W), .UA_W(UA_W), .N_COND(N_COND), .CSEL_W(CSEL_W),
    .N_DISP(N_DISP), .DISP_BASE(DISP_BASE), .DISP_STRIDE(DISP_STRIDE),
    .ILLEGAL_UA(ILLEGAL_UA)
  ) u_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode), .condFlags(condFlags),
    .seqMode(seqMode), .condSel(condSel),
    .strobe(strobe), .dispTarget(dispTarget)
  );

  useq_path #(.UA_W(UA_W), .OFF_W(OFF_W)) u_path (
    .clk(clk), .rst(rst), .strobe(strobe), .dispTarget(dispTarget),
    .brOffset(brOffset), .uPc(uAddr)
  );

  // R4
  illegal_disp_chk: assert property (@(posedge clk) disable iff (rst)
    (seqMode == MODE_DISP && opcode >= OP_W'(N_DISP)) |=> uAddr == UA_W'(ILLEGAL_UA));

  // R3
  legal_disp_chk: assert property (@(posedge clk) disable iff (rst)
    (seqMode == MODE_DISP && opcode < OP_W'(N_DISP))
      |=> uAddr == UA_W'(DISP_BASE + DISP_STRIDE * $past(opcode)));

  // R6
  branch_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (seqMode == MODE_BRANCH && condFlags[condSel])
      |=> uAddr == UA_W'($past(uAddr) + {{(UA_W-OFF_W){$past(brOffset[OFF_W-1])}}, $past(brOffset)}));

  // R7 R8
  branch_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (seqMode == MODE_BRANCH && !condFlags[condSel]) |=> uAddr == UA_W'($past(uAddr) + 1));

endmodule

// File: tb/sim_useq_top.sv
`timescale 1ns/1ps
module sim_useq_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = '0;
  logic [3:0] condFlags = '0;
  logic [1:0] seqMode = '0;
  logic [1:0] condSel = '0;
  logic [4:0] brOffset = '0;
  logic [7:0] uAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  useq_top u0 (
    .clk(clk), .rst(rst), .opcode(opcode), .condFlags(condFlags),
    .seqMode(seqMode), .condSel(condSel), .brOffset(brOffset), .uAddr(uAddr)
  );

  // Row: {mode, opcode, flags, sel, offset, expected uAddr, requirement}
  localparam int NV = 18;
  localparam logic [30:0] VEC [NV] = '{
    {2'd2, 6'd0,  4'b0000, 2'd0, 5'd0,  8'h01, 4'd5}, // R5
    {2'd2, 6'd0,  4'b0000, 2'd0, 5'd0,  8'h02, 4'd5}, // R5
    {2'd1, 6'd3,  4'b0000, 2'd0, 5'd0,  8'h28, 4'd3}, // R3
    {2'd2, 6'd0,  4'b0000, 2'd0, 5'd0,  8'h29, 4'd5}, // R5
    {2'd3, 6'd0,  4'b0001, 2'd0, 5'd5,  8'h2E, 4'd6}, // R6 overflow taken
    {2'd3, 6'd0,  4'b1101, 2'd1, 5'd7,  8'h2F, 4'd8}, // R8 others set, selected clear
    {2'd3, 6'd0,  4'b0010, 2'd1, 5'h10, 8'h1F, 4'd6}, // R6 interrupt, offset -16
    {2'd1, 6'd0,  4'b0000, 2'd0, 5'd0,  8'h10, 4'd3}, // R3
    {2'd1, 6'd5,  4'b0000, 2'd0, 5'd0,  8'h38, 4'd3}, // R3 last legal opcode
    {2'd1, 6'd6,  4'b0000, 2'd0, 5'd0,  8'hF0, 4'd4}, // R4 first illegal
    {2'd1, 6'd63, 4'b0000, 2'd0, 5'd0,  8'hF0, 4'd4}, // R4 largest opcode
    {2'd2, 6'd0,  4'b0000, 2'd0, 5'd0,  8'hF1, 4'd5}, // R5
    {2'd3, 6'd0,  4'b1000, 2'd3, 5'd15, 8'h00, 4'd6}, // R6 wraps past 0xFF
    {2'd3, 6'd0,  4'b0100, 2'd2, 5'h1F, 8'hFF, 4'd6}, // R6 offset -1 below zero
    {2'd2, 6'd0,  4'b0000, 2'd0, 5'd0,  8'h00, 4'd5}, // R5 wrap 0xFF to 0x00
    {2'd1, 6'd1,  4'b0000, 2'd0, 5'd0,  8'h18, 4'd3}, // R3
    {2'd0, 6'd9,  4'b1111, 2'd0, 5'd3,  8'h00, 4'd2}, // R2 fetch
    {2'd3, 6'd0,  4'b1011, 2'd2, 5'd3,  8'h01, 4'd7}  // R7 not taken, R8
  };

  task automatic check(input logic [7:0] exp, input int req);
    checks++;
    if (uAddr !== exp) begin
      errors++;
      $display("FAIL R%0d uAddr actual %h expected %h", req, uAddr, exp);
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    seqMode = 2'd2;
    repeat (3) @(negedge clk);
    check(8'h00, 1);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      seqMode   = VEC[i][30:29];
      opcode    = VEC[i][28:23];
      condFlags = VEC[i][22:19];
      condSel   = VEC[i][18:17];
      brOffset  = VEC[i][16:12];
      @(negedge clk);
      check(VEC[i][11:4], int'(VEC[i][3:0]));
    end

    // R1: reset wins over a dispatch in the same cycle
    seqMode = 2'd1; opcode = 6'd2; rst = 1'b1;
    @(negedge clk);
    check(8'h00, 1);
    // R3: dispatch resumes once reset drops
    rst = 1'b0;
    @(negedge clk);
    check(8'h20, 3);
    // R8: all unselected flags set, selected clear, falls through
    seqMode = 2'd3; condSel = 2'd0; condFlags = 4'b1110; brOffset = 5'd9;
    @(negedge clk);
    check(8'h21, 8);
    // R6: only the selected flag set, branch taken
    condSel = 2'd3; condFlags = 4'b1000;
    @(negedge clk);
    check(8'h2A, 6);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule